// File: doc/BRIEF.md
# Debug Command Frame Receiver

This block sits between a serial byte link and a debug command engine. It watches a stream of received bytes, each marked by a one-cycle valid strobe, and assembles them into command frames made of a function code, a payload length, the payload and a trailing checksum. Every byte it accepts is written into an external frame buffer through a simple write port, at a position fixed by the frame layout, so the command engine can read the whole frame once it is complete.

A frame is accepted only if its function code is in the recognised range, its length does not exceed the payload ceiling, and the 8-bit sum of all its bytes, checksum included, is zero. There is no start-of-frame marker. The receiver resynchronises by hunting for a byte that can be a function code, and by dropping any partial frame when the link goes quiet for longer than a programmable number of clock cycles. A frame that fails any check is dropped without any indication. A good frame gives a one-cycle ready pulse with its function code and length. After that the receiver ignores the link until the command engine reports completion.

Top module: `dbg_frame_rx`

## Requirements
- R1: While hunting, a byte below FN_MIN (default 0xF7) is discarded with no buffer write, and the receiver keeps hunting. A byte at or above FN_MIN starts a frame.
- R2: A length byte greater than MAX_LEN (default 128) aborts the frame. The byte is not written, and the next byte is treated as a candidate function code.
- R3: A length of zero skips the payload, and the byte that follows the length is taken as the checksum.
- R4: Accepted bytes are written to the buffer one cycle after acceptance: function code at address 0, length at address 1, payload byte i at address 2+i, checksum at address length+2.
- R5: When the 8-bit sum of function, length, payload and checksum is zero, frame_ready is high in the cycle after the checksum is accepted (the same cycle as the checksum write), with frame_fn and frame_len giving the frame's code and length.
- R6: A frame whose sum is not zero produces no frame_ready, and reception restarts at the function code.
- R7: Inside a frame, a gap of TIMEOUT_CYC clock cycles with no byte discards the partial frame, and the next byte is treated as a candidate function code. A gap of TIMEOUT_CYC-1 cycles keeps the frame.
- R8: From frame_ready until an exec_done strobe, incoming bytes are ignored, with no buffer write and no further frame_ready. After exec_done, hunting resumes.
- R9: While in reset, and after reset, frame_ready and buf_we are low until a byte is received.
- R10: frame_ready is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| exec_done | input | 1 | Command engine has finished with the frame |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | ADDR_W | Frame buffer write address |
| buf_wdata | output | 8 | Frame buffer write data |
| frame_ready | output | 1 | One-cycle pulse for a validated frame |
| frame_fn | output | 8 | Function code of the frame |
| frame_len | output | 8 | Payload length of the frame |

## Verification
On every cycle the assertions check the following: the ready pulse lasts one cycle, it coincides with the checksum write at address length+2, and the reported code and length lie inside their legal ranges. They also check that no buffer write happens between a ready pulse and the completion strobe. What only the bench scenarios can show is whether the right frames are accepted or dropped. This covers every payload length, every function code, lengths around the ceiling, corrupted checksums, gaps on either side of the timeout, and the exact buffer contents, all compared against sums computed in the bench.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  typedef enum logic [2:0] {
    ST_FN   = 3'd0,
    ST_LEN  = 3'd1,
    ST_DATA = 3'd2,
    ST_SUM  = 3'd3,
    ST_HOLD = 3'd4
  } dfr_state_e;
endpackage

// File: rtl/dfr_rst_sync.sv
module dfr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dfr_idle_timer.sv
module dfr_idle_timer #(
  parameter int TIMEOUT_CYC = 25000000,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic kick,
  output logic expire
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);
  assign expire   = run && !kick && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || kick)  cnt_d = '0;
    else if (at_limit) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dfr_sum_acc.sv
module dfr_sum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum_q
);
  logic [7:0] sum_d;
  logic       sum_en;

  assign sum_en = load || add;

  always_comb begin
    if (load) sum_d = din;
    else      sum_d = sum_q + din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end
endmodule

// File: rtl/dfr_wr_port.sv
module dfr_wr_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_we <= 1'b0;
    else        buf_we <= wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_addr  <= '0;
      buf_wdata <= '0;
    end else if (wr_en) begin
      buf_addr  <= wr_addr;
      buf_wdata <= wr_data;
    end
  end
endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
  import dfr_pkg::*;
#(
  parameter int         MAX_LEN     = 128,
  parameter logic [7:0] FN_MIN      = 8'hF7,
  parameter int         TIMEOUT_CYC = 25000000,
  localparam int        ADDR_W      = $clog2(MAX_LEN + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              exec_done,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              frame_ready,
  output logic [7:0]        frame_fn,
  output logic [7:0]        frame_len
);
  localparam logic [8:0] LEN_CEIL = 9'(MAX_LEN);

  logic              rst_ns;
  dfr_state_e        st_q, st_d;
  logic [7:0]        fn_q, len_q, idx_q, idx_d, len_d;
  logic              fn_en, len_en, idx_en;
  logic              ready_q, ready_d;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              sum_load, sum_add;
  logic [7:0]        sum_q, sum_tot;
  logic              in_frame, kick, expire;
  logic              len_ok, last_pay;

  dfr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns)
  );

  assign in_frame = (st_q == ST_LEN) || (st_q == ST_DATA) || (st_q == ST_SUM);
  assign kick     = in_frame && rx_valid;

  dfr_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_ns), .run(in_frame), .kick(kick), .expire(expire)
  );

  dfr_sum_acc u_sum (
    .clk(clk), .rst_n(rst_ns), .load(sum_load), .add(sum_add),
    .din(rx_data), .sum_q(sum_q)
  );

  assign sum_tot  = sum_q + rx_data;
  assign len_ok   = ({1'b0, rx_data} <= LEN_CEIL);
  assign last_pay = (idx_q == (len_q - 8'd1));

  always_comb begin
    st_d     = st_q;
    wr_en    = 1'b0;
    wr_addr  = '0;
    sum_load = 1'b0;
    sum_add  = 1'b0;
    ready_d  = 1'b0;
    fn_en    = 1'b0;
    len_en   = 1'b0;
    len_d    = rx_data;
    idx_en   = 1'b0;
    idx_d    = idx_q;
    unique case (st_q)
      ST_FN: begin
        if (rx_valid && (rx_data >= FN_MIN)) begin
          wr_en    = 1'b1;
          wr_addr  = '0;
          sum_load = 1'b1;
          fn_en    = 1'b1;
          st_d     = ST_LEN;
        end
      end
      ST_LEN: begin
        if (expire) begin
          st_d = ST_FN;
        end else if (rx_valid) begin
          if (len_ok) begin
            wr_en   = 1'b1;
            wr_addr = ADDR_W'(1);
            sum_add = 1'b1;
            len_en  = 1'b1;
            idx_en  = 1'b1;
            idx_d   = '0;
            st_d    = (rx_data == 8'd0) ? ST_SUM : ST_DATA;
          end else begin
            st_d = ST_FN;
          end
        end
      end
      ST_DATA: begin
        if (expire) begin
          st_d = ST_FN;
        end else if (rx_valid) begin
          wr_en   = 1'b1;
          wr_addr = ADDR_W'({1'b0, idx_q} + 9'd2);
          sum_add = 1'b1;
          idx_en  = 1'b1;
          idx_d   = idx_q + 8'd1;
          if (last_pay) st_d = ST_SUM;
        end
      end
      ST_SUM: begin
        if (expire) begin
          st_d = ST_FN;
        end else if (rx_valid) begin
          wr_en   = 1'b1;
          wr_addr = ADDR_W'({1'b0, len_q} + 9'd2);
          if (sum_tot == 8'd0) begin
            ready_d = 1'b1;
            st_d    = ST_HOLD;
          end else begin
            st_d = ST_FN;
          end
        end
      end
      ST_HOLD: begin
        if (exec_done) st_d = ST_FN;
      end
      default: st_d = ST_FN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q    <= ST_FN;
      ready_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)    fn_q <= '0;
    else if (fn_en) fn_q <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  dfr_wr_port #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(rx_data), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata)
  );

  assign frame_ready = ready_q;
  assign frame_fn    = fn_q;
  assign frame_len   = len_q;
endmodule

// File: rtl/dbg_frame_rx_chk.sv
module dbg_frame_rx_chk #(
  parameter int         MAX_LEN = 128,
  parameter logic [7:0] FN_MIN  = 8'hF7,
  parameter int         ADDR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_done,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              frame_ready,
  input logic [7:0]        frame_fn,
  input logic [7:0]        frame_len
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           busy_q <= 1'b0;
    else if (exec_done)   busy_q <= 1'b0;
    else if (frame_ready) busy_q <= 1'b1;
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready); // R10
  AST_READY_FN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (frame_fn >= FN_MIN)); // R1
  AST_READY_LEN_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> ({1'b0, frame_len} <= 9'(MAX_LEN))); // R2
  AST_READY_WITH_SUM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (buf_we && ({1'b0, buf_addr} == ({1'b0, frame_len} + 9'd2)))); // R5
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !buf_we); // R8
endmodule

bind dbg_frame_rx dbg_frame_rx_chk #(
  .MAX_LEN(MAX_LEN), .FN_MIN(FN_MIN), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_done(exec_done), .buf_we(buf_we),
  .buf_addr(buf_addr), .frame_ready(frame_ready), .frame_fn(frame_fn),
  .frame_len(frame_len)
);

// File: tb/dbg_frame_rx_tb.sv
module dbg_frame_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_LEN    = 128;
  localparam int TMO        = 16;
  localparam int AW         = $clog2(MAX_LEN + 3);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_valid;
  logic [7:0]    rx_data;
  logic          exec_done;
  logic          buf_we;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_wdata;
  logic          frame_ready;
  logic [7:0]    frame_fn;
  logic [7:0]    frame_len;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  int rdy_cnt = 0;
  int dbl_cnt = 0;
  logic prev_rdy = 1'b0;
  logic [7:0] last_fn, last_len;
  logic [7:0] mem [0:MAX_LEN+2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_frame_rx #(.MAX_LEN(MAX_LEN), .FN_MIN(8'hF7), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .exec_done(exec_done), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .frame_ready(frame_ready), .frame_fn(frame_fn),
    .frame_len(frame_len)
  );

  always @(posedge clk) begin
    #1;
    if (buf_we) begin
      mem[buf_addr] = buf_wdata;
      wr_cnt++;
    end
    if (frame_ready) begin
      rdy_cnt++;
      last_fn  = frame_fn;
      last_len = frame_len;
    end
    if (frame_ready && prev_rdy) dbl_cnt++;
    prev_rdy = frame_ready;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pay(input int i, input int len);
    return 8'((i * 37 + len * 5 + 3) & 255);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic clear_cnt();
    wr_cnt  = 0;
    rdy_cnt = 0;
    for (int i = 0; i <= MAX_LEN + 2; i++) mem[i] = 8'hxx;
  endtask

  task automatic send_frame(input logic [7:0] fn, input int len, input bit good,
                            input int gap);
    logic [7:0] s;
    s = fn + 8'(len);
    send_byte(fn, gap);
    send_byte(8'(len), gap);
    for (int i = 0; i < len; i++) begin
      s = s + pay(i, len);
      send_byte(pay(i, len), gap);
    end
    send_byte(good ? (8'd0 - s) : (8'd1 - s), gap);
  endtask

  task automatic done_pulse();
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_good(input logic [7:0] fn, input int len, input string tag);
    int bad;
    logic [7:0] s;
    idle(3);
    chk(rdy_cnt == 1, {tag, " ready count"}, rdy_cnt, 1);
    chk(last_fn == fn && last_len == 8'(len), {tag, " fn/len"},
        {last_fn, last_len}, {fn, 8'(len)});
    chk(wr_cnt == len + 3, {tag, " write count"}, wr_cnt, len + 3);
    bad = 0;
    s = fn + 8'(len);
    if (mem[0] !== fn || mem[1] !== 8'(len)) bad++;
    for (int i = 0; i < len; i++) begin
      s = s + pay(i, len);
      if (mem[2 + i] !== pay(i, len)) bad++;
    end
    if (mem[len + 2] !== 8'(8'd0 - s)) bad++;
    chk(bad == 0, {tag, " buffer layout"}, bad, 0);
    done_pulse();
    clear_cnt();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    rx_valid = 1'b0;
    rx_data = 8'h00;
    exec_done = 1'b0;
    clear_cnt();
    idle(3);
    chk(frame_ready == 1'b0 && buf_we == 1'b0, "R9 in reset", frame_ready, 0);
    rst_n = 1'b1;
    idle(5);
    chk(frame_ready == 1'b0 && buf_we == 1'b0 && wr_cnt == 0,
        "R9 after reset", wr_cnt, 0);

    // R4 R5 R3: every payload length, function codes cycling over the legal range
    for (int l = 0; l <= MAX_LEN; l++) begin
      logic [7:0] f;
      f = 8'(8'hF7 + (l % 9));
      send_frame(f, l, 1'b1, (l % 3 == 0) ? 1 : 0);
      check_good(f, l, (l == 0) ? "R3 zero length" : "R4/R5 length sweep");
    end

    // R1: every function code value
    for (int f = 0; f < 256; f++) begin
      send_byte(8'(f), 0);
      idle(2);
      if (f < 247) begin
        chk(wr_cnt == 0, "R1 low code ignored", wr_cnt, 0);
        send_frame(8'hF8, 1, 1'b1, 0);
        check_good(8'hF8, 1, "R1 recovery");
      end else begin
        chk(wr_cnt == 1 && mem[0] == 8'(f), "R1 code accepted", wr_cnt, 1);
        idle(TMO + 2);
        clear_cnt();
      end
    end

    // R2: lengths around the ceiling
    for (int l = MAX_LEN - 2; l <= 255; l++) begin
      if (l <= MAX_LEN) begin
        send_frame(8'hF9, l, 1'b1, 0);
        check_good(8'hF9, l, "R2 at ceiling");
      end else if (l < MAX_LEN + 6 || l == 255) begin
        send_byte(8'hF9, 0);
        send_byte(8'(l), 0);
        idle(2);
        chk(wr_cnt == 1 && rdy_cnt == 0, "R2 oversize dropped", wr_cnt, 1);
        send_byte(8'h10, 0);
        idle(2);
        chk(wr_cnt == 1, "R2 back to hunting", wr_cnt, 1);
        clear_cnt();
        send_frame(8'hFA, 2, 1'b1, 0);
        check_good(8'hFA, 2, "R2 recovery");
      end
    end

    // R6: corrupted checksum
    for (int l = 0; l < 6; l++) begin
      send_frame(8'hFB, l, 1'b0, 0);
      idle(3);
      chk(rdy_cnt == 0, "R6 bad sum no ready", rdy_cnt, 0);
      chk(wr_cnt == l + 3, "R6 bytes still written", wr_cnt, l + 3);
      clear_cnt();
      send_frame(8'hFC, l, 1'b1, 0);
      check_good(8'hFC, l, "R6 recovery");
    end

    // R7: gap just inside the timeout keeps the frame
    send_frame(8'hFD, 4, 1'b1, TMO - 1);
    check_good(8'hFD, 4, "R7 gap below timeout");

    // R7: gap equal to the timeout drops the frame
    send_byte(8'hFE, 0);
    send_byte(8'd4, 0);
    send_byte(8'h01, TMO);
    send_byte(8'h05, 0);
    idle(3);
    chk(wr_cnt == 3 && rdy_cnt == 0, "R7 timeout drop", wr_cnt, 3);
    clear_cnt();
    send_frame(8'hF7, 3, 1'b1, 0);
    check_good(8'hF7, 3, "R7 recovery");

    // R8: bytes ignored while awaiting completion
    send_frame(8'hFF, 2, 1'b1, 0);
    idle(3);
    chk(rdy_cnt == 1, "R8 first frame ready", rdy_cnt, 1);
    clear_cnt();
    send_frame(8'hF8, 1, 1'b1, 0);
    send_byte(8'hF9, 0);
    idle(3);
    chk(wr_cnt == 0 && rdy_cnt == 0, "R8 ignored while held", wr_cnt, 0);
    done_pulse();
    clear_cnt();
    send_frame(8'hFA, 5, 1'b1, 0);
    check_good(8'hFA, 5, "R8 after done");

    chk(dbl_cnt == 0, "R10 single-cycle ready", dbl_cnt, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule